// File: doc/BRIEF.md
# One-Time-Programmable Area Sequencer

This block guards a small one-time-programmable region that lives beside a main memory array. Bus requests arrive on a valid/ready request channel carrying a write flag, an address and 16-bit data. While the block is in array mode it only watches the low byte of write data for an entry sequence. Once inside the protected mode it serves reads from eight stored words and a lock word, and it runs program operations on that storage. The main array itself is served elsewhere; the `otp_mode` output tells the surrounding logic which path owns the bus.

Half of the region (four words) holds factory content fixed by a parameter and can never be programmed. The other four words start erased (all ones) and accept programming until a single lock bit is cleared. A program only clears bits: the written data is ANDed into the stored word. Programming takes a parameterised number of cycles, and during that window reads return the status byte instead of content.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each accepted read produces one response; `rsp_valid` stays high and `rsp_data` stays constant until `rsp_ready` is seen high. While a response waits, `req_ready` is low and no request of either kind is taken. Writes produce no response.

Top module: `otp_seq`

## Requirements
- R1: After reset the block is in array mode: `otp_mode`=0, `busy`=0, `req_ready`=1, `rsp_valid`=0, `status`=80h.
- R2: Two consecutive accepted writes whose low data byte is AFh switch to protected mode at the edge taking the second; any other accepted write in between restarts the count, while reads do not.
- R3: In protected mode with no program pending, two consecutive accepted writes with low byte FFh return to array mode; any other write in between restarts the count; leaving clears the lock-error flag.
- R4: In array mode reads answer 0000h and writes never alter the protected storage.
- R5: In protected mode reads at addresses 0 to 3 return factory words 0 to 3 (word i is bits 16i+15:16i of the factory parameter), addresses 4 to 7 return the user words, address 40h returns the lock bit in bit 15 with ones in bits 14:0, and every other address returns FFFFh.
- R6: A write with low byte 40h or 10h followed by an address/data write programs that word: the new value is the old value AND the data, applied after PROG_CYCLES cycles; the address/data write never counts toward the leave sequence.
- R7: While a program runs, `busy`=1, reads answer {00h, status byte}, and writes are dropped.
- R8: A program aimed at a factory word or an unmapped address is refused: no busy window, content unchanged, status bit 1 (lock error) set.
- R9: Programming address 40h ANDs data bit 15 into the lock bit; once it is 0 it never returns to 1 and programs to user words are refused as in R8.
- R10: The status byte has bit 7 = ready (not busy), bit 1 = lock error, all other bits 0; responses obey the back-pressure rules above.
- R11: When a program ends the block stays in protected mode with `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; presets storage |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data; low byte carries commands |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DW | Read response data |
| otp_mode | output | 1 | 1 while in protected mode |
| busy | output | 1 | 1 while a program runs |
| status | output | 8 | Status byte (bit 7 ready, bit 1 lock error) |

## Verification
The bench builds the block with PROG_CYCLES set to 5 and a factory pattern whose four words all differ, keeping the default 8-bit address and 16-bit data. The short programming window lets a status read and a dropped write land inside a running program and still leaves time for the leave sequence, while the distinct factory words expose any wrong word index. A behavioural model tracks mode, sequence counts, storage and the response channel and is compared on every cycle, alongside directed checks on broken sequences, refusals, the lock bit and a stalled response.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SETUP = 2'd2,
    MODE_BUSY  = 2'd3
  } otp_mode_e;

  localparam logic [7:0] CODE_ENTER  = 8'hAF;
  localparam logic [7:0] CODE_LEAVE  = 8'hFF;
  localparam logic [7:0] CODE_PROG_A = 8'h40;
  localparam logic [7:0] CODE_PROG_B = 8'h10;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_LKERR_BIT = 1;

  function automatic logic [7:0] pack_status(input logic running, input logic lock_err);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_READY_BIT] = ~running;
    s[STAT_LKERR_BIT] = lock_err;
    return s;
  endfunction

endpackage

// File: rtl/otp_pair_detect.sv
module otp_pair_detect #(
  parameter logic [7:0] CODE = 8'hAF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       wr_evt,
  input  logic [7:0] code_in,
  output logic       hit
);

  logic seen_q;
  logic match;

  assign match = wr_evt && (code_in == CODE);
  assign hit   = arm && match && seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (!arm) begin
      seen_q <= 1'b0;
    end else if (wr_evt) begin
      seen_q <= match && !seen_q;
    end
  end

endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int               AW           = 8,
  parameter int               DW           = 16,
  parameter int               FACT_WORDS   = 4,
  parameter int               USER_WORDS   = 4,
  parameter logic [FACT_WORDS*DW-1:0] FACTORY_DATA = '0,
  parameter logic [AW-1:0]    LOCK_ADDR    = 'h40,
  parameter int               LOCK_BIT     = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] chk_addr,
  output logic          pg_allowed,
  input  logic          commit,
  input  logic [AW-1:0] pg_addr,
  input  logic [DW-1:0] pg_data,
  output logic          lock_open
);

  localparam int TOTAL = FACT_WORDS + USER_WORDS;

  logic [DW-1:0] user_q [USER_WORDS];
  logic          lock_q;

  for (genvar u = 0; u < USER_WORDS; u++) begin : g_user
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        user_q[u] <= '1;
      end else if (commit && pg_addr == AW'(FACT_WORDS + u)) begin
        user_q[u] <= user_q[u] & pg_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (commit && pg_addr == LOCK_ADDR) begin
      lock_q <= lock_q & pg_data[LOCK_BIT];
    end
  end

  assign lock_open = lock_q;

  always_comb begin
    rd_data = '1;
    if (rd_addr == LOCK_ADDR) begin
      rd_data[LOCK_BIT] = lock_q;
    end
    for (int i = 0; i < FACT_WORDS; i++) begin
      if (rd_addr == AW'(i)) rd_data = FACTORY_DATA[i*DW +: DW];
    end
    for (int i = 0; i < USER_WORDS; i++) begin
      if (rd_addr == AW'(FACT_WORDS + i)) rd_data = user_q[i];
    end
  end

  always_comb begin
    pg_allowed = 1'b0;
    if (chk_addr == LOCK_ADDR) begin
      pg_allowed = 1'b1;
    end else if (chk_addr >= AW'(FACT_WORDS) && chk_addr < AW'(TOTAL)) begin
      pg_allowed = lock_q;
    end
  end

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter int               AW           = 8,
  parameter int               DW           = 16,
  parameter int               FACT_WORDS   = 4,
  parameter int               USER_WORDS   = 4,
  parameter logic [FACT_WORDS*DW-1:0] FACTORY_DATA = 64'hC0DE_5A5A_0F0F_1234,
  parameter logic [AW-1:0]    LOCK_ADDR    = 'h40,
  parameter int               PROG_CYCLES  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          otp_mode,
  output logic          busy,
  output logic [7:0]    status
);

  localparam int CW       = $clog2(PROG_CYCLES + 1);
  localparam int LOCK_BIT = DW - 1;

  otp_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] paddr_q;
  logic [DW-1:0] pdata_q;
  logic          lockerr_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  logic          fire, wr_evt, rd_evt;
  logic [7:0]    code;
  logic          enter_hit, leave_hit;
  logic          prog_cmd;
  logic [DW-1:0] store_rd;
  logic          pg_allowed;
  logic          commit;
  logic          user_locked;
  logic          lock_open;

  assign req_ready = !rsp_valid_q;
  assign fire      = req_valid && req_ready;
  assign wr_evt    = fire && req_write;
  assign rd_evt    = fire && !req_write;
  assign code      = req_wdata[7:0];
  assign prog_cmd  = (code == CODE_PROG_A) || (code == CODE_PROG_B);
  assign commit    = (mode_q == MODE_BUSY) && (cnt_q == '0);

  otp_pair_detect #(.CODE(CODE_ENTER)) u_enter (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (mode_q == MODE_ARRAY),
    .wr_evt  (wr_evt),
    .code_in (code),
    .hit     (enter_hit)
  );

  otp_pair_detect #(.CODE(CODE_LEAVE)) u_leave (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (mode_q == MODE_IDLE),
    .wr_evt  (wr_evt),
    .code_in (code),
    .hit     (leave_hit)
  );

  otp_store #(
    .AW           (AW),
    .DW           (DW),
    .FACT_WORDS   (FACT_WORDS),
    .USER_WORDS   (USER_WORDS),
    .FACTORY_DATA (FACTORY_DATA),
    .LOCK_ADDR    (LOCK_ADDR),
    .LOCK_BIT     (LOCK_BIT)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (req_addr),
    .rd_data    (store_rd),
    .chk_addr   (req_addr),
    .pg_allowed (pg_allowed),
    .commit     (commit),
    .pg_addr    (paddr_q),
    .pg_data    (pdata_q),
    .lock_open  (lock_open)
  );

  assign user_locked = !lock_open;

  // mode sequencing and program window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_ARRAY;
      cnt_q     <= '0;
      paddr_q   <= '0;
      pdata_q   <= '0;
      lockerr_q <= 1'b0;
    end else begin
      unique case (mode_q)
        MODE_ARRAY: begin
          if (enter_hit) mode_q <= MODE_IDLE;
        end
        MODE_IDLE: begin
          if (leave_hit) begin
            mode_q    <= MODE_ARRAY;
            lockerr_q <= 1'b0;
          end else if (wr_evt && prog_cmd) begin
            mode_q <= MODE_SETUP;
          end
        end
        MODE_SETUP: begin
          if (wr_evt) begin
            if (pg_allowed) begin
              mode_q  <= MODE_BUSY;
              cnt_q   <= CW'(PROG_CYCLES - 1);
              paddr_q <= req_addr;
              pdata_q <= req_wdata;
            end else begin
              mode_q    <= MODE_IDLE;
              lockerr_q <= 1'b1;
            end
          end
        end
        MODE_BUSY: begin
          if (cnt_q == '0) mode_q <= MODE_IDLE;
          else             cnt_q  <= cnt_q - 1'b1;
        end
        default: mode_q <= MODE_ARRAY;
      endcase
    end
  end

  // read response channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_evt) begin
      rsp_valid_q <= 1'b1;
      if (mode_q == MODE_BUSY)       rsp_data_q <= DW'(pack_status(1'b1, lockerr_q));
      else if (mode_q == MODE_ARRAY) rsp_data_q <= '0;
      else                           rsp_data_q <= store_rd;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign otp_mode  = (mode_q != MODE_ARRAY);
  assign busy      = (mode_q == MODE_BUSY);
  assign status    = pack_status(busy, lockerr_q);

endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          otp_mode,
  input logic          busy,
  input logic [7:0]    status,
  input logic          user_locked
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10

  AST_ENTER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_mode) |-> $past(req_valid && req_ready && req_write && req_wdata[7:0] == 8'hAF)); // R2

  AST_LEAVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otp_mode) |-> $past(req_valid && req_ready && req_write && req_wdata[7:0] == 8'hFF)); // R3

  AST_BUSY_IN_OTP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> otp_mode); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !status[7]); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    user_locked |=> user_locked); // R9

  AST_STATUS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'h7D) == 8'h00); // R10

endmodule

bind otp_seq otp_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .otp_mode    (otp_mode),
  .busy        (busy),
  .status      (status),
  .user_locked (user_locked)
);

// File: tb/otp_seq_tb.sv
`timescale 1ns/1ps
module otp_seq_tb;

  localparam int          PC   = 5;
  localparam logic [63:0] FACT = 64'h1357_9BDF_2468_ACE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, otp_mode, busy;
  logic [15:0] rsp_data;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  otp_seq #(.PROG_CYCLES(PC), .FACTORY_DATA(FACT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .otp_mode(otp_mode), .busy(busy), .status(status)
  );

  // ---------------- behavioural reference model ----------------
  int          m_mode = 0;  // 0 array, 1 idle, 2 setup, 3 programming
  bit          m_ent = 0, m_ext = 0, m_lock = 1, m_lockerr = 0, m_rv = 0;
  int          m_cnt = 0;
  int          m_pa = 0;
  logic [15:0] m_pd = '0, m_rd = '0;
  logic [15:0] m_user [4] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};

  function automatic logic [7:0] m_status();
    return {(m_mode != 3), 5'b0, m_lockerr, 1'b0};
  endfunction

  function automatic logic [15:0] m_read(input int a);
    if (a < 4) return FACT[a*16 +: 16];
    if (a < 8) return m_user[a-4];
    if (a == 64) return {m_lock, 15'h7FFF};
    return 16'hFFFF;
  endfunction

  function automatic bit m_allowed(input int a);
    return (a == 64) || (a >= 4 && a < 8 && m_lock);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit f, w, r;
    logic [7:0] c;
    if (!rst_n) begin
      m_mode = 0; m_ent = 0; m_ext = 0; m_lock = 1; m_lockerr = 0; m_rv = 0;
      m_cnt = 0; m_rd = '0;
      for (int i = 0; i < 4; i++) m_user[i] = 16'hFFFF;
    end else begin
      f = req_valid && !m_rv;
      w = f && req_write;
      r = f && !req_write;
      c = req_wdata[7:0];
      if (m_rv && rsp_ready) m_rv = 0;
      if (r) begin
        m_rv = 1;
        if (m_mode == 3)      m_rd = {8'h00, m_status()};
        else if (m_mode == 0) m_rd = 16'h0000;
        else                  m_rd = m_read(int'(req_addr));
      end
      case (m_mode)
        0: if (w) begin
             if (c == 8'hAF) begin
               if (m_ent) begin m_mode = 1; m_ent = 0; end else m_ent = 1;
             end else m_ent = 0;
           end
        1: if (w) begin
             if (c == 8'hFF) begin
               if (m_ext) begin m_mode = 0; m_ext = 0; m_lockerr = 0; end else m_ext = 1;
             end else begin
               m_ext = 0;
               if (c == 8'h40 || c == 8'h10) m_mode = 2;
             end
           end
        2: if (w) begin
             if (m_allowed(int'(req_addr))) begin
               m_mode = 3; m_cnt = PC - 1; m_pa = int'(req_addr); m_pd = req_wdata;
             end else begin
               m_mode = 1; m_lockerr = 1;
             end
           end
        default: begin
          if (m_cnt == 0) begin
            if (m_pa >= 4 && m_pa < 8) m_user[m_pa-4] = m_user[m_pa-4] & m_pd;
            if (m_pa == 64) m_lock = m_lock & m_pd[15];
            m_mode = 1;
          end else m_cnt--;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (otp_mode !== (m_mode != 0) || busy !== (m_mode == 3) || status !== m_status() ||
          req_ready !== !m_rv || rsp_valid !== m_rv || (m_rv && rsp_data !== m_rd)) begin
        fails++;
        $display("FAIL per-cycle model, all requirements: act mode=%0b busy=%0b st=%h rdy=%0b rv=%0b rd=%h exp mode=%0b busy=%0b st=%h rdy=%0b rv=%0b rd=%h",
                 otp_mode, busy, status, req_ready, rsp_valid, rsp_data,
                 (m_mode != 0), (m_mode == 3), m_status(), !m_rv, m_rv, m_rd);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int stall, output logic [15:0] d);
    logic [15:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 stalled response held", {15'b0, rsp_valid, rsp_data}, {15'b0, 1'b1, first});
      chk("R10 no request taken while response waits", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    d = rsp_data;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [15:0] d;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", {31'b0, otp_mode}, 32'd0);
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R1 reset ready", {30'b0, req_ready, rsp_valid}, 32'd2);
    chk("R1 reset status", {24'b0, status}, 32'h80);

    rd(8'h00, 0, d);               chk("R4 array-mode read", {16'b0, d}, 32'h0000);
    wr(8'h00, 16'h0040);
    wr(8'h04, 16'h0000);           // program attempt in array mode: no effect
    wr(8'h00, 16'h00AF);
    wr(8'h00, 16'h0012);
    wr(8'h00, 16'h00AF);
    idle(1);
    chk("R2 broken entry stays in array mode", {31'b0, otp_mode}, 32'd0);
    rd(8'h00, 0, d);               // a read does not break the pair
    wr(8'h00, 16'h00AF);
    idle(1);
    chk("R2 entry after two AFh writes", {31'b0, otp_mode}, 32'd1);

    rd(8'h04, 0, d);               chk("R4 array-mode write left user word", {16'b0, d}, 32'hFFFF);
    rd(8'h00, 0, d);               chk("R5 factory word 0", {16'b0, d}, 32'hACE0);
    rd(8'h03, 0, d);               chk("R5 factory word 3", {16'b0, d}, 32'h1357);
    rd(8'h40, 0, d);               chk("R5 lock word while open", {16'b0, d}, 32'hFFFF);
    rd(8'h09, 0, d);               chk("R5 unmapped address", {16'b0, d}, 32'hFFFF);

    wr(8'h00, 16'h0040);
    wr(8'h05, 16'hF0F0);
    chk("R7 busy after address/data write", {31'b0, busy}, 32'd1);
    rd(8'h05, 0, d);               chk("R7 read while programming gives status", {16'b0, d}, 32'h0000);
    wr(8'h00, 16'h0040);           // dropped: still programming
    idle(4);
    chk("R11 stays in protected mode after program", {30'b0, otp_mode, busy}, 32'd2);
    wr(8'h06, 16'h0000);           // would program word 6 if the earlier 40h had been taken
    idle(PC + 2);
    rd(8'h06, 0, d);               chk("R7 write during program dropped", {16'b0, d}, 32'hFFFF);
    rd(8'h05, 0, d);               chk("R6 programmed word", {16'b0, d}, 32'hF0F0);

    wr(8'h00, 16'h0040);
    wr(8'h05, 16'h0FFF);
    idle(PC + 1);
    rd(8'h05, 0, d);               chk("R6 program ANDs into word", {16'b0, d}, 32'h00F0);
    wr(8'h00, 16'h0010);
    wr(8'h07, 16'h1234);
    idle(PC + 1);
    rd(8'h07, 0, d);               chk("R6 alternate setup code", {16'b0, d}, 32'h1234);

    wr(8'h00, 16'h0040);
    wr(8'h01, 16'h0000);
    chk("R8 factory program refused, no busy", {31'b0, busy}, 32'd0);
    chk("R8 lock error flagged", {24'b0, status}, 32'h82);
    rd(8'h01, 0, d);               chk("R8 factory word unchanged", {16'b0, d}, 32'h2468);
    wr(8'h00, 16'h0040);
    wr(8'h20, 16'h0000);
    chk("R8 unmapped program refused", {30'b0, busy, status[1]}, 32'd1);

    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h0040);
    wr(8'h04, 16'h00FF);           // data byte FFh must not count toward leaving
    idle(PC + 1);
    wr(8'h00, 16'h00FF);
    idle(1);
    chk("R3 broken leave stays in protected mode", {31'b0, otp_mode}, 32'd1);
    chk("R6 data write not counted as leave code", {31'b0, otp_mode}, 32'd1);
    rd(8'h04, 3, d);               chk("R10 stalled read data", {16'b0, d}, 32'h00FF);
    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h00FF);
    idle(1);
    chk("R3 leave after two FFh writes", {31'b0, otp_mode}, 32'd0);
    chk("R3 leaving clears lock error", {24'b0, status}, 32'h80);
    rd(8'h05, 0, d);               chk("R4 array mode hides protected data", {16'b0, d}, 32'h0000);

    wr(8'h00, 16'h00AF);
    wr(8'h00, 16'h00AF);
    rd(8'h05, 0, d);               chk("R6 content kept across modes", {16'b0, d}, 32'h00F0);
    wr(8'h00, 16'h0040);
    wr(8'h40, 16'h7FFF);
    idle(PC + 1);
    rd(8'h40, 0, d);               chk("R9 lock bit programmed", {16'b0, d}, 32'h7FFF);
    wr(8'h00, 16'h0040);
    wr(8'h04, 16'h0000);
    chk("R9 locked user word refused", {24'b0, status}, 32'h82);
    rd(8'h04, 0, d);               chk("R9 locked user word unchanged", {16'b0, d}, 32'h00FF);
    wr(8'h00, 16'h0040);
    wr(8'h40, 16'hFFFF);
    idle(PC + 1);
    rd(8'h40, 0, d);               chk("R9 lock cannot return to one", {16'b0, d}, 32'h7FFF);
    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h00FF);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule